// File: doc/BRIEF.md
# Descriptor-Driven Block DMA Engine

This engine moves data for several DMA channels over one memory master port. No channel keeps its settings in local registers. Each channel owns a three-word descriptor in system memory. When a trigger arrives with a channel number, the engine works out where that channel's descriptor sits and reads it. It then copies one block of data units from the source pointer to the destination pointer and writes the updated descriptor back to the same place. A channel that has to move N blocks therefore receives N triggers, and the transfer counter in its descriptor tracks how many remain.

Triggers from hardware also update that channel's interrupt bits when the block ends. The engine drives a one-cycle clear strobe for the interrupt factor flag, for the DMA request bit and for the DMA enable bit, so the interrupt controller that holds those bits can apply them. Software triggers leave those bits untouched.

The control is a seven-state machine.
- ST_IDLE waits for a trigger.
- ST_FETCH reads descriptor words 0, 1 and 2 and moves to ST_DECIDE after the third word.
- ST_DECIDE has three exits. A mode other than block returns to ST_IDLE. A block length of zero goes to ST_SAVE. Any other block length goes to ST_READ.
- ST_READ fetches one unit and moves to ST_WRITE.
- ST_WRITE stores that unit. It returns to ST_READ while units remain and goes to ST_SAVE after the last one.
- ST_SAVE writes the three words back. It then goes to ST_NOTIFY for a hardware trigger, or to ST_IDLE for a software trigger.
- ST_NOTIFY emits the clear strobes and returns to ST_IDLE.

Top module: `blkdma_engine`

## Requirements
- R1: While reset is held and right after it, busy is 0, mem_req is 0 and no clear strobe is active.
- R2: A trigger on channel c reads three words, at base_addr+12c, +4 and +8. If word0[1:0] is not 2'b10 (block mode), the engine makes no further memory access and returns to idle.
- R3: One trigger moves exactly L units, where L is word0[15:8]. Each unit is a read from the source pointer followed by a write to the destination pointer. word0[5:4] sets the unit size: 00 is a byte, 01 is a halfword, and 10 or 11 is a word. Narrow units are right-aligned on mem_rdata and mem_wdata.
- R4: The source pointer is word1[27:0] and is stepped by word1[29:28]. The destination pointer is word2[27:0] and is stepped by word2[29:28]. In both fields, 00 holds the pointer, 01 subtracts the unit size in bytes, and 10 or 11 adds it.
- R5: A pointer whose step field is 10 is written back with its initial value. The block length is written back as its initial value if either step field is 10, and as 0 otherwise. Any other pointer is written back with its stepped value.
- R6: After the block, the three words are written back to the addresses they were read from. word0[31:16] (the transfer counter) is decremented by one. Every other field keeps its value.
- R7: After a hardware trigger, with k the decremented counter and e = word2[31]:
  - k ≠ 0: the factor flag is cleared.
  - k = 0 and e = 1: the request bit is cleared.
  - k = 0 and e = 0: the factor flag and the enable bit are cleared.
  - Each strobe is a one-cycle pulse on bit c.
- R8: A software trigger produces no clear strobe.
- R9: busy rises in the cycle after a trigger is accepted and falls after write-back, or after the strobes for a hardware trigger. A trigger that arrives while busy is ignored.
- R10: A block length of 0 moves no data unit. The descriptor is still written back with the counter decremented.
- R11: While mem_req is high and mem_ready is low, the request, address, write flag and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trig_req | input | 1 | Trigger request, accepted when idle |
| trig_chan | input | CHW | Channel of the trigger |
| trig_hw | input | 1 | 1 for a hardware trigger, 0 for a software trigger |
| base_addr | input | AW | Start address of the descriptor table |
| busy | output | 1 | Engine is processing a trigger |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write access |
| mem_addr | output | AW | Byte address of the access |
| mem_size | output | 2 | Access size: 00 byte, 01 halfword, 10 word |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned, valid with mem_ready |
| mem_ready | input | 1 | Access completes in a cycle with mem_req high |
| flag_clr | output | NCH | Clear strobe for the interrupt factor flag, per channel |
| req_clr | output | NCH | Clear strobe for the DMA request bit, per channel |
| en_clr | output | NCH | Clear strobe for the DMA enable bit, per channel |

## Verification
Directed descriptors cover each kind of block:
- word units stepping up, across two triggers on the same channel, which shows that the stored pointers carry over;
- halfword units with reload on both pointers, which separates reload from plain stepping;
- byte units stepping down;
- fixed pointers with a software trigger;
- a zero block length;
- a mode other than block;
- a trigger that arrives while busy.

The three directed hardware-trigger cases each select a different row of the interrupt table.

Random descriptors then mix unit size, step fields, length, counter, interrupt enable and trigger kind. A stalling ready line runs throughout. After each trigger, a byte-level memory model is compared in full against the real memory. This exposes wrong step sizes, wrong directions, wrong reload choices and stray writes.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
    // descriptor word 0
    localparam int CNT_LSB  = 16;
    localparam int CNT_W    = 16;
    localparam int LEN_LSB  = 8;
    localparam int LEN_W    = 8;
    localparam int SZ_LSB   = 4;
    localparam int MODE_LSB = 0;
    // descriptor words 1 and 2
    localparam int PTR_W    = 28;
    localparam int STEP_LSB = 28;
    localparam int IE_BIT   = 31;
    localparam int DESC_WORDS = 3;

    localparam logic [1:0] MODE_BLOCK  = 2'b10;
    localparam logic [1:0] STEP_HOLD   = 2'b00;
    localparam logic [1:0] STEP_DOWN   = 2'b01;
    localparam logic [1:0] STEP_RELOAD = 2'b10;
    localparam logic [1:0] SIZE_WORD   = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECIDE,
        ST_READ,
        ST_WRITE,
        ST_SAVE,
        ST_NOTIFY
    } dma_state_e;
endpackage

// File: rtl/blkdma_step.sv
module blkdma_step
    import blkdma_pkg::*;
(
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [1:0]       step_i,
    input  logic [1:0]       size_i,
    output logic [PTR_W-1:0] ptr_o
);
    logic [PTR_W-1:0] delta;

    always_comb begin
        delta = '0;
        unique case (size_i)
            2'b00:   delta[0] = 1'b1;
            2'b01:   delta[1] = 1'b1;
            default: delta[2] = 1'b1;
        endcase
    end

    always_comb begin
        unique case (step_i)
            STEP_HOLD: ptr_o = ptr_i;
            STEP_DOWN: ptr_o = ptr_i - delta;
            default:   ptr_o = ptr_i + delta;
        endcase
    end
endmodule

// File: rtl/blkdma_irqdec.sv
module blkdma_irqdec #(
    parameter int NCH = 8,
    parameter int CHW = 3
) (
    input  logic           fire_i,
    input  logic [CHW-1:0] chan_i,
    input  logic           last_i,
    input  logic           ie_i,
    output logic [NCH-1:0] flag_clr_o,
    output logic [NCH-1:0] req_clr_o,
    output logic [NCH-1:0] en_clr_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic sel;
        assign sel           = fire_i && (chan_i == CHW'(g));
        assign flag_clr_o[g] = sel && (!last_i || !ie_i);
        assign req_clr_o[g]  = sel && last_i && ie_i;
        assign en_clr_o[g]   = sel && last_i && !ie_i;
    end
endmodule

// File: rtl/blkdma_engine.sv
module blkdma_engine
    import blkdma_pkg::*;
#(
    parameter  int NCH = 8,
    parameter  int AW  = 32,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           trig_req,
    input  logic [CHW-1:0] trig_chan,
    input  logic           trig_hw,
    input  logic [AW-1:0]  base_addr,
    output logic           busy,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     mem_size,
    output logic [31:0]    mem_wdata,
    input  logic [31:0]    mem_rdata,
    input  logic           mem_ready,
    output logic [NCH-1:0] flag_clr,
    output logic [NCH-1:0] req_clr,
    output logic [NCH-1:0] en_clr
);
    localparam logic [1:0] LAST_IDX = 2'(DESC_WORDS - 1);

    dma_state_e state_q, state_d;
    logic [1:0]       idx_q;
    logic [31:0]      w0_q, w1_q, w2_q;
    logic [PTR_W-1:0] src_q, dst_q, src_nx, dst_nx;
    logic [LEN_W-1:0] len_q;
    logic [31:0]      unit_q, unit_in;
    logic [CHW-1:0]   chan_q;
    logic             hw_q;
    logic [AW-1:0]    dadr_q;

    // fields of the fetched descriptor
    logic [1:0]       f_mode, f_size, f_sstep, f_dstep;
    logic [LEN_W-1:0] f_len;
    logic [CNT_W-1:0] f_cnt, cnt_dec;
    logic [PTR_W-1:0] f_src, f_dst;
    logic             f_ie, xfer;
    logic [31:0]      wb0, wb1, wb2;

    assign f_mode  = w0_q[MODE_LSB +: 2];
    assign f_size  = w0_q[SZ_LSB +: 2];
    assign f_len   = w0_q[LEN_LSB +: LEN_W];
    assign f_cnt   = w0_q[CNT_LSB +: CNT_W];
    assign f_sstep = w1_q[STEP_LSB +: 2];
    assign f_src   = w1_q[PTR_W-1:0];
    assign f_dstep = w2_q[STEP_LSB +: 2];
    assign f_dst   = w2_q[PTR_W-1:0];
    assign f_ie    = w2_q[IE_BIT];
    assign cnt_dec = f_cnt - CNT_W'(1);
    assign xfer    = mem_req && mem_ready;

    blkdma_step u_src_step (.ptr_i(src_q), .step_i(f_sstep), .size_i(f_size), .ptr_o(src_nx));
    blkdma_step u_dst_step (.ptr_i(dst_q), .step_i(f_dstep), .size_i(f_size), .ptr_o(dst_nx));

    blkdma_irqdec #(.NCH(NCH), .CHW(CHW)) u_irq (
        .fire_i    (state_q == ST_NOTIFY),
        .chan_i    (chan_q),
        .last_i    (cnt_dec == '0),
        .ie_i      (f_ie),
        .flag_clr_o(flag_clr),
        .req_clr_o (req_clr),
        .en_clr_o  (en_clr)
    );

    // write-back images
    assign wb0 = {cnt_dec,
                  ((f_sstep == STEP_RELOAD) || (f_dstep == STEP_RELOAD)) ? f_len : len_q,
                  w0_q[LEN_LSB-1:0]};
    assign wb1 = {w1_q[31:PTR_W], (f_sstep == STEP_RELOAD) ? f_src : src_q};
    assign wb2 = {w2_q[31:PTR_W], (f_dstep == STEP_RELOAD) ? f_dst : dst_q};

    always_comb begin
        unique case (f_size)
            2'b00:   unit_in = {24'b0, mem_rdata[7:0]};
            2'b01:   unit_in = {16'b0, mem_rdata[15:0]};
            default: unit_in = mem_rdata;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (trig_req) state_d = ST_FETCH;
            ST_FETCH:  if (xfer && idx_q == LAST_IDX) state_d = ST_DECIDE;
            ST_DECIDE: begin
                if (f_mode != MODE_BLOCK) state_d = ST_IDLE;
                else if (f_len == '0)     state_d = ST_SAVE;
                else                      state_d = ST_READ;
            end
            ST_READ:   if (xfer) state_d = ST_WRITE;
            ST_WRITE:  if (xfer) state_d = (len_q == LEN_W'(1)) ? ST_SAVE : ST_READ;
            ST_SAVE:   if (xfer && idx_q == LAST_IDX) state_d = hw_q ? ST_NOTIFY : ST_IDLE;
            ST_NOTIFY: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dadr_q + AW'({idx_q, 2'b00});
        mem_size  = SIZE_WORD;
        mem_wdata = '0;
        unique case (state_q)
            ST_FETCH: mem_req = 1'b1;
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = AW'(src_q);
                mem_size = f_size;
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = AW'(dst_q);
                mem_size  = f_size;
                mem_wdata = unit_q;
            end
            ST_SAVE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                unique case (idx_q)
                    2'd0:    mem_wdata = wb0;
                    2'd1:    mem_wdata = wb1;
                    default: mem_wdata = wb2;
                endcase
            end
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            w0_q   <= '0;
            w1_q   <= '0;
            w2_q   <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            len_q  <= '0;
            unit_q <= '0;
            chan_q <= '0;
            hw_q   <= 1'b0;
            dadr_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (trig_req) begin
                    chan_q <= trig_chan;
                    hw_q   <= trig_hw;
                    dadr_q <= base_addr + (AW'(trig_chan) << 3) + (AW'(trig_chan) << 2);
                    idx_q  <= '0;
                end
                ST_FETCH: if (xfer) begin
                    unique case (idx_q)
                        2'd0:    w0_q <= mem_rdata;
                        2'd1:    w1_q <= mem_rdata;
                        default: w2_q <= mem_rdata;
                    endcase
                    idx_q <= idx_q + 2'd1;
                end
                ST_DECIDE: begin
                    src_q <= f_src;
                    dst_q <= f_dst;
                    len_q <= f_len;
                    idx_q <= '0;
                end
                ST_READ: if (xfer) unit_q <= unit_in;
                ST_WRITE: if (xfer) begin
                    src_q <= src_nx;
                    dst_q <= dst_nx;
                    len_q <= len_q - LEN_W'(1);
                end
                ST_SAVE: if (xfer) idx_q <= idx_q + 2'd1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/blkdma_chk.sv
module blkdma_chk #(
    parameter int NCH = 8,
    parameter int AW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           mem_req,
    input logic           mem_we,
    input logic           mem_ready,
    input logic [AW-1:0]  mem_addr,
    input logic [31:0]    mem_wdata,
    input logic [NCH-1:0] flag_clr,
    input logic [NCH-1:0] req_clr,
    input logic [NCH-1:0] en_clr
);
    // R11: a stalled access keeps its request and attributes
    p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R9: the bus is used only while busy
    p_bus_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R7: strobes address a single channel
    p_clr_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr | req_clr | en_clr));

    // R7: enable clear only comes together with flag clear, never with request clear
    p_en_with_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_clr) |-> (en_clr == flag_clr) && (req_clr == '0));

    // R9: strobes are the last busy cycle and carry no bus access
    p_done_after_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_clr | req_clr)) |-> !mem_req ##1 !busy);
endmodule

bind blkdma_engine blkdma_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .flag_clr(flag_clr), .req_clr(req_clr), .en_clr(en_clr)
);

// File: tb/sim_blkdma_engine.sv
module sim_blkdma_engine;
    localparam int NCH = 8;
    localparam int AW  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_req = 1'b0;
    logic [2:0] trig_chan = '0;
    logic trig_hw = 1'b0;
    logic [AW-1:0] base_addr = 32'h40;
    logic busy, mem_req, mem_we, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [1:0] mem_size;
    logic [31:0] mem_wdata, mem_rdata;
    logic [NCH-1:0] flag_clr, req_clr, en_clr;

    always #5 clk = ~clk;

    blkdma_engine #(.NCH(NCH), .AW(AW)) u0 (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // memory model with host write port, log and stall monitor
    logic [7:0]  mem [0:4095];
    logic [7:0]  ref_mem [0:4095];
    logic        host_we = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_data = '0;
    logic        log_clr = 1'b0;
    logic [31:0] log_addr [0:63];
    logic        log_we [0:63];
    int          log_n = 0;
    logic [NCH-1:0] st_f = '0, st_r = '0, st_e = '0;
    int          stall_err = 0;
    logic        stall_q = 1'b0;
    logic [31:0] stall_addr = '0;

    always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

    always_comb begin
        logic [11:0] a;
        a = mem_addr[11:0];
        case (mem_size)
            2'b00:   mem_rdata = {24'b0, mem[a]};
            2'b01:   mem_rdata = {16'b0, mem[a + 12'd1], mem[a]};
            default: mem_rdata = {mem[a + 12'd3], mem[a + 12'd2], mem[a + 12'd1], mem[a]};
        endcase
    end

    always @(posedge clk) begin
        if (host_we) begin
            for (int b = 0; b < 4; b++) mem[host_addr + 12'(b)] <= host_data[8*b +: 8];
        end else if (mem_req && mem_ready && mem_we) begin
            for (int b = 0; b < 4; b++)
                if (b < (mem_size == 2'b00 ? 1 : mem_size == 2'b01 ? 2 : 4))
                    mem[mem_addr[11:0] + 12'(b)] <= mem_wdata[8*b +: 8];
        end
        if (log_clr) begin
            log_n <= 0; st_f <= '0; st_r <= '0; st_e <= '0;
            stall_err <= 0; stall_q <= 1'b0;
        end else begin
            if (mem_req && mem_ready && log_n < 64) begin
                log_addr[log_n] <= mem_addr;
                log_we[log_n]   <= mem_we;
                log_n <= log_n + 1;
            end
            st_f <= st_f | flag_clr;
            st_r <= st_r | req_clr;
            st_e <= st_e | en_clr;
            if (stall_q && (!mem_req || mem_addr != stall_addr)) stall_err <= stall_err + 1;
            stall_q    <= mem_req && !mem_ready;
            stall_addr <= mem_addr;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic host_word(input int a, input logic [31:0] d);
        host_we = 1'b1; host_addr = 12'(a); host_data = d;
        @(negedge clk);
        host_we = 1'b0;
        for (int b = 0; b < 4; b++) ref_mem[(a + b) & 12'hFFF] = d[8*b +: 8];
    endtask

    function automatic logic [31:0] rd32(input int a);
        return {ref_mem[(a+3) & 12'hFFF], ref_mem[(a+2) & 12'hFFF],
                ref_mem[(a+1) & 12'hFFF], ref_mem[a & 12'hFFF]};
    endfunction

    function automatic logic [31:0] mk_w0(input int cnt, input int len, input int sz, input int mode);
        return {16'(cnt), 8'(len), 2'b00, 2'(sz), 2'b00, 2'(mode)};
    endfunction

    function automatic logic [31:0] mk_wp(input bit ie, input int step, input int ptr);
        return {ie, 1'b0, 2'(step), 28'(ptr)};
    endfunction

    task automatic set_desc(input int ch, input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        int da;
        da = int'(base_addr) + ch * 12;
        host_word(da, a); host_word(da + 4, b); host_word(da + 8, c);
    endtask

    function automatic int step_ptr(input int p, input int st, input int nb);
        if (st == 0) return p;
        if (st == 1) return p - nb;
        return p + nb;
    endfunction

    // reference model of one trigger, applied to ref_mem
    task automatic ref_run(input int ch, input bit hw, output int n_acc,
                           output logic [7:0] ef, output logic [7:0] er, output logic [7:0] ee);
        logic [31:0] w0, w1, w2;
        int da, len, nb, s, d, si, di, cnt, nl, ns, nd;
        da = int'(base_addr) + ch * 12;
        w0 = rd32(da); w1 = rd32(da + 4); w2 = rd32(da + 8);
        ef = '0; er = '0; ee = '0;
        if (w0[1:0] != 2'b10) begin n_acc = 3; return; end
        len = int'(w0[15:8]);
        nb  = (w0[5:4] == 2'b00) ? 1 : (w0[5:4] == 2'b01) ? 2 : 4;
        s = int'(w1[27:0]); d = int'(w2[27:0]);
        si = int'(w1[29:28]); di = int'(w2[29:28]);
        for (int k = 0; k < len; k++) begin
            for (int b = 0; b < nb; b++) ref_mem[(d + b) & 12'hFFF] = ref_mem[(s + b) & 12'hFFF];
            s = step_ptr(s, si, nb);
            d = step_ptr(d, di, nb);
        end
        cnt = (int'(w0[31:16]) - 1) & 16'hFFFF;
        nl = (si == 2 || di == 2) ? len : 0;
        ns = (si == 2) ? int'(w1[27:0]) : s;
        nd = (di == 2) ? int'(w2[27:0]) : d;
        begin
            logic [31:0] n0, n1, n2;
            n0 = {16'(cnt), 8'(nl), w0[7:0]};
            n1 = {w1[31:28], 28'(ns)};
            n2 = {w2[31:28], 28'(nd)};
            for (int b = 0; b < 4; b++) begin
                ref_mem[(da + b) & 12'hFFF]     = n0[8*b +: 8];
                ref_mem[(da + 4 + b) & 12'hFFF] = n1[8*b +: 8];
                ref_mem[(da + 8 + b) & 12'hFFF] = n2[8*b +: 8];
            end
        end
        n_acc = 6 + 2 * len;
        if (hw) begin
            if (cnt != 0)   ef[ch] = 1'b1;
            else if (w2[31]) er[ch] = 1'b1;
            else begin ef[ch] = 1'b1; ee[ch] = 1'b1; end
        end
    endtask

    task automatic run_trig(input int ch, input bit hw, input bit intrude);
        int n_acc, wd, bad, da;
        logic [7:0] ef, er, ee;
        da = int'(base_addr) + ch * 12;
        log_clr = 1'b1; @(negedge clk); log_clr = 1'b0;
        ref_run(ch, hw, n_acc, ef, er, ee);
        trig_req = 1'b1; trig_chan = 3'(ch); trig_hw = hw;
        @(negedge clk);
        trig_req = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", longint'(busy), 1);
        if (intrude) begin
            trig_req = 1'b1; trig_chan = 3'((ch + 3) % 8); trig_hw = 1'b1;
            @(negedge clk);
            trig_req = 1'b0;
        end
        wd = 0;
        while (busy && wd < 3000) begin @(negedge clk); wd++; end
        chk(wd < 3000, "R9 busy ends", longint'(wd), 0);
        bad = 0;
        for (int i = 0; i < 4096; i++) if (mem[i] !== ref_mem[i]) bad++;
        chk(bad == 0, "R3/R4/R5/R6 memory image mismatched bytes", longint'(bad), 0);
        chk(log_n == n_acc, "R3/R10 access count", longint'(log_n), longint'(n_acc));
        for (int j = 0; j < 3; j++)
            chk(log_addr[j] == 32'(da + 4*j) && !log_we[j], "R2 descriptor read address",
                longint'(log_addr[j]), longint'(da + 4*j));
        chk({st_f, st_r, st_e} == {ef, er, ee}, hw ? "R7 clear strobes" : "R8 no strobes",
            longint'({st_f, st_r, st_e}), longint'({ef, er, ee}));
        chk(stall_err == 0, "R11 stalled access held", longint'(stall_err), 0);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && flag_clr == '0 && req_clr == '0 && en_clr == '0,
            "R1 in reset", longint'({busy, mem_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 1024; i++) host_word(4*i, $urandom);
        chk(!busy && !mem_req && (flag_clr | req_clr | en_clr) == '0,
            "R1 after reset", longint'({busy, mem_req}), 0);

        // directed corner cases
        set_desc(0, mk_w0(3, 4, 2, 2), mk_wp(0, 3, 'h300), mk_wp(1, 3, 'h900));
        run_trig(0, 1, 0);
        set_desc(1, mk_w0(1, 3, 1, 2), mk_wp(0, 2, 'h340), mk_wp(1, 2, 'h940));
        run_trig(1, 1, 0);
        set_desc(2, mk_w0(1, 5, 0, 2), mk_wp(0, 1, 'h500), mk_wp(0, 1, 'hB00));
        run_trig(2, 1, 0);
        set_desc(3, mk_w0(2, 2, 2, 2), mk_wp(0, 0, 'h380), mk_wp(1, 0, 'h980));
        run_trig(3, 0, 0);
        set_desc(4, mk_w0(2, 0, 2, 2), mk_wp(0, 3, 'h3C0), mk_wp(1, 3, 'h9C0));
        run_trig(4, 1, 0);  // R10 zero length
        set_desc(5, mk_w0(2, 4, 2, 1), mk_wp(0, 3, 'h400), mk_wp(1, 3, 'hA00));
        run_trig(5, 1, 0);  // R2 non-block mode
        set_desc(6, mk_w0(2, 3, 2, 2), mk_wp(0, 3, 'h440), mk_wp(1, 3, 'hA40));
        run_trig(6, 1, 1);  // R9 trigger while busy ignored
        run_trig(0, 1, 0);  // second block on channel 0 continues pointers

        // random descriptors
        for (int t = 0; t < 40; t++) begin
            int ch, mode, len;
            ch   = int'($urandom % 8);
            mode = ($urandom % 8 == 0) ? int'($urandom % 2) : 2;
            len  = ($urandom % 6 == 0) ? 0 : 1 + int'($urandom % 6);
            base_addr = ($urandom % 2) ? 32'h40 : 32'h80;
            set_desc(ch, mk_w0(1 + int'($urandom % 3), len, int'($urandom % 4), mode),
                     mk_wp(0, int'($urandom % 4), ('h300 + int'($urandom % 'h300)) & ~3),
                     mk_wp(1'($urandom), int'($urandom % 4), ('h900 + int'($urandom % 'h300)) & ~3));
            run_trig(ch, 1'($urandom), ($urandom % 5) == 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule